// File: doc/BRIEF.md
# Alert-on-Update Line Monitor

This block keeps one alert mark for each line of a small direct-mapped cache. When a marked line is written by another agent, invalidated by a snoop, or forced out by a capacity or conflict replacement, the processor is told. The monitor holds a copy of the tag of each marked line. It raises a one-cycle alert strobe, records the line address, the cause, the program counter that was current, and the handler vector to branch to. The result acts as a spontaneous subroutine call. It replaces a silent loss of the line.

The processor drives a command stream (valid/ready) that sets or clears the user handler vector, sets the kernel-mode vector, performs an alert-load, releases one line, or releases every line. An alert-load marks the addressed line. It also returns the word that the data array presents on `ld_word` through a response stream (valid/ready). A response that the processor has not taken is held stable. While it is held, `cmd_ready` is low, so the command stream stalls. Snoop and eviction notices arrive on plain strobed ports and cannot be stalled. The bench acts as the processor, the coherence agent and the data array.

Top module: `alert_monitor`

## Requirements
- R1: An accepted alert-load (op code 2) marks the line at `cmd_addr` (index = low `log2(NUM_LINES)` bits, tag = the remaining bits). One cycle later it presents `ld_word` on `rsp_word` with `rsp_valid` high. While `rsp_valid` is high and `rsp_ready` is low, the response holds and `cmd_ready` is low.
- R2: Release (op 3) clears the mark of the addressed line only, and only if the stored tag matches. Release-all (op 4) clears every mark in one cycle.
- R3: Clear-handler (op 1) sets `handler_pc` to zero and clears every mark. Set-handler (op 0) loads `cmd_pc` into `handler_pc`. Set-kernel-vector (op 5) loads `cmd_pc` into `kernel_vec`.
- R4: A snoop whose address matches a marked line is an event with cause 1 (remote write) and clears that mark. A snoop to an unmarked line, or to a line whose stored tag differs, does nothing.
- R5: An eviction notice that matches a marked line is an event with cause 3 (eviction) and clears the mark. An alert-load to an index whose marked tag differs is an eviction event for the old line's address.
- R6: A reported event raises `alert_o` for exactly the cycle after the event, together with `alert_pending`. It loads `alert_addr` and `alert_cause`, and captures `cur_pc` of the event cycle into `old_pc`.
- R7: `alert_target` captures `kernel_vec` when `kmode` is high in the event cycle, otherwise `handler_pc`.
- R8: When the selected vector is zero, an event is dropped. There is no strobe and no change to the alert record, and the mark is still cleared.
- R9: An event while an alert is pending and not acknowledged in that cycle sets `alert_cause` to 2 (lost alert). It keeps `alert_addr` and gives no strobe. `alert_ack` clears pending, and an event in the ack cycle is reported as new.
- R10: Events in one cycle are ranked snoop, then eviction notice, then alert-load conflict. The highest one's address is reported, and the cause is 2 if more than one occurred.
- R11: Snoop and eviction lookups see the marks as they were before the same cycle's command. A release and a snoop of the same line in one cycle still alert, and an alert-load in the same cycle as a snoop hit leaves the line marked.
- R12: After reset all marks, registers, strobes and `rsp_valid` are zero and `cmd_ready` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command accepted when high with cmd_valid |
| cmd_op | input | 3 | 0 set handler, 1 clear handler, 2 alert-load, 3 release, 4 release all, 5 set kernel vector |
| cmd_addr | input | ADDR_W | Line address for alert-load and release |
| cmd_pc | input | PC_W | Vector value for set commands |
| ld_word | input | WORD_W | Word from the data array for the alert-load |
| rsp_valid | output | 1 | Alert-load response present |
| rsp_ready | input | 1 | Processor takes the response |
| rsp_word | output | WORD_W | Returned word |
| snp_valid | input | 1 | Remote write or invalidate notice |
| snp_addr | input | ADDR_W | Snooped line address |
| ev_valid | input | 1 | Capacity/conflict eviction notice |
| ev_addr | input | ADDR_W | Evicted line address |
| kmode | input | 1 | Processor is in kernel mode |
| cur_pc | input | PC_W | Current program counter |
| alert_ack | input | 1 | Handler has taken the alert |
| alert_o | output | 1 | One-cycle alert strobe |
| alert_pending | output | 1 | Alert not yet acknowledged |
| alert_addr | output | ADDR_W | Line that caused the alert |
| alert_cause | output | 2 | 0 none, 1 remote write, 2 lost alert, 3 eviction |
| alert_target | output | PC_W | Vector to call |
| handler_pc | output | PC_W | User handler vector |
| kernel_vec | output | PC_W | Kernel handler vector |
| old_pc | output | PC_W | PC captured at the alert |

## Verification
Two kinds of collision are driven on purpose. In the first, a command and a snoop or eviction notice land on the same line in the same cycle: a release or an alert-load meets a snoop hit. The alert must reflect the marks as they stood before the command, and the line's final mark must follow the command. In the second, several events arrive in one cycle, or an event meets a pending alert or its acknowledge. Directed cases set these up by hand. A long random phase then confines addresses to a few tags so that such overlaps recur often. Every output is compared each cycle against a behavioural model that keeps marks in plain arrays.

// File: rtl/am_pkg.sv
package am_pkg;
  typedef enum logic [2:0] {
    OP_SET_HND  = 3'd0,
    OP_CLR_HND  = 3'd1,
    OP_ALOAD    = 3'd2,
    OP_RELEASE  = 3'd3,
    OP_REL_ALL  = 3'd4,
    OP_SET_KVEC = 3'd5
  } am_op_e;

  typedef enum logic [1:0] {
    CAUSE_NONE  = 2'd0,
    CAUSE_WRITE = 2'd1,
    CAUSE_LOST  = 2'd2,
    CAUSE_EVICT = 2'd3
  } am_cause_e;
endpackage

// File: rtl/am_mark_array.sv
module am_mark_array #(
  parameter int NUM_LINES = 8,
  parameter int IDX_W     = 3,
  parameter int TAG_W     = 9
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flash_clr,
  input  logic             set_en,
  input  logic [IDX_W-1:0] set_idx,
  input  logic [TAG_W-1:0] set_tag,
  input  logic             rel_en,
  input  logic [IDX_W-1:0] rel_idx,
  input  logic [TAG_W-1:0] rel_tag,
  input  logic             a_vld,
  input  logic [IDX_W-1:0] a_idx,
  input  logic [TAG_W-1:0] a_tag,
  output logic             a_hit,
  input  logic             b_vld,
  input  logic [IDX_W-1:0] b_idx,
  input  logic [TAG_W-1:0] b_tag,
  output logic             b_hit,
  output logic             c_conf,
  output logic [TAG_W-1:0] c_old_tag
);
  logic             mark_q [NUM_LINES];
  logic [TAG_W-1:0] tag_q  [NUM_LINES];
  logic [NUM_LINES-1:0] mark_vec;

  assign a_hit     = a_vld && mark_q[a_idx] && (tag_q[a_idx] == a_tag);
  assign b_hit     = b_vld && mark_q[b_idx] && (tag_q[b_idx] == b_tag);
  assign c_conf    = set_en && mark_q[set_idx] && (tag_q[set_idx] != set_tag);
  assign c_old_tag = tag_q[set_idx];

  for (genvar i = 0; i < NUM_LINES; i++) begin : g_line
    logic drop;
    assign drop = (a_hit && (a_idx == IDX_W'(i))) ||
                  (b_hit && (b_idx == IDX_W'(i))) ||
                  (rel_en && (rel_idx == IDX_W'(i)) && (tag_q[i] == rel_tag));
    assign mark_vec[i] = mark_q[i];

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        mark_q[i] <= 1'b0;
        tag_q[i]  <= '0;
      end else if (flash_clr) begin
        mark_q[i] <= 1'b0;
      end else if (set_en && (set_idx == IDX_W'(i))) begin
        mark_q[i] <= 1'b1;
        tag_q[i]  <= set_tag;
      end else if (drop) begin
        mark_q[i] <= 1'b0;
      end
    end
  end

  AST_MARK_SET: assert property (@(posedge clk) disable iff (!rst_n)
    (set_en && !flash_clr) |=> mark_vec[$past(set_idx)]); // R1
  AST_FLASH_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    flash_clr |=> (mark_vec == '0)); // R2
endmodule

// File: rtl/am_event_arb.sv
module am_event_arb
  import am_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              s_hit,
  input  logic [ADDR_W-1:0] s_addr,
  input  logic              e_hit,
  input  logic [ADDR_W-1:0] e_addr,
  input  logic              c_hit,
  input  logic [ADDR_W-1:0] c_addr,
  output logic              evt,
  output logic              evt_multi,
  output logic [ADDR_W-1:0] evt_addr,
  output am_cause_e         evt_cause
);
  logic [1:0] n_evt;

  assign n_evt     = 2'(s_hit) + 2'(e_hit) + 2'(c_hit);
  assign evt       = n_evt != 2'd0;
  assign evt_multi = n_evt > 2'd1;

  always_comb begin
    evt_addr  = c_addr;
    evt_cause = CAUSE_EVICT;
    if (s_hit) begin
      evt_addr  = s_addr;
      evt_cause = CAUSE_WRITE;
    end else if (e_hit) begin
      evt_addr  = e_addr;
    end
  end
endmodule

// File: rtl/am_alert_regs.sv
module am_alert_regs
  import am_pkg::*;
#(
  parameter int ADDR_W = 12,
  parameter int PC_W   = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_hnd,
  input  logic              clr_hnd,
  input  logic              set_kvec,
  input  logic [PC_W-1:0]   vec_in,
  input  logic              evt,
  input  logic              evt_multi,
  input  logic [ADDR_W-1:0] evt_addr,
  input  am_cause_e         evt_cause,
  input  logic              kmode,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              ack,
  output logic              alert_o,
  output logic              pending,
  output logic [ADDR_W-1:0] addr_o,
  output am_cause_e         cause_o,
  output logic [PC_W-1:0]   target_o,
  output logic [PC_W-1:0]   handler_o,
  output logic [PC_W-1:0]   kvec_o,
  output logic [PC_W-1:0]   old_pc_o
);
  logic [PC_W-1:0] sel_vec;
  logic            pend_eff;
  logic            raise;

  assign sel_vec  = kmode ? kvec_o : handler_o;
  assign pend_eff = pending && !ack;
  assign raise    = evt && !pend_eff && (sel_vec != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      alert_o   <= 1'b0;
      pending   <= 1'b0;
      addr_o    <= '0;
      cause_o   <= CAUSE_NONE;
      target_o  <= '0;
      old_pc_o  <= '0;
      handler_o <= '0;
      kvec_o    <= '0;
    end else begin
      alert_o <= raise;
      pending <= pend_eff || raise;
      if (raise) begin
        addr_o   <= evt_addr;
        cause_o  <= evt_multi ? CAUSE_LOST : evt_cause;
        target_o <= sel_vec;
        old_pc_o <= cur_pc;
      end else if (evt && pend_eff) begin
        cause_o <= CAUSE_LOST;
      end
      if (set_hnd)      handler_o <= vec_in;
      else if (clr_hnd) handler_o <= '0;
      if (set_kvec)     kvec_o    <= vec_in;
    end
  end

  AST_STROBE_PENDING: assert property (@(posedge clk) disable iff (!rst_n)
    alert_o |-> pending); // R6
  AST_LOST_KEEPS_ADDR: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && pending && !ack) |=> (!alert_o && $stable(addr_o) && cause_o == CAUSE_LOST)); // R9
  AST_NO_VECTOR_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (evt && !kmode && handler_o == '0) |=> !alert_o); // R8
  AST_HANDLER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_hnd && !set_hnd) |=> (handler_o == '0)); // R3
endmodule

// File: rtl/alert_monitor.sv
module alert_monitor
  import am_pkg::*;
#(
  parameter int NUM_LINES = 8,
  parameter int ADDR_W    = 12,
  parameter int PC_W      = 16,
  parameter int WORD_W    = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [2:0]        cmd_op,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic [PC_W-1:0]   cmd_pc,
  input  logic [WORD_W-1:0] ld_word,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [WORD_W-1:0] rsp_word,
  input  logic              snp_valid,
  input  logic [ADDR_W-1:0] snp_addr,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_addr,
  input  logic              kmode,
  input  logic [PC_W-1:0]   cur_pc,
  input  logic              alert_ack,
  output logic              alert_o,
  output logic              alert_pending,
  output logic [ADDR_W-1:0] alert_addr,
  output logic [1:0]        alert_cause,
  output logic [PC_W-1:0]   alert_target,
  output logic [PC_W-1:0]   handler_pc,
  output logic [PC_W-1:0]   kernel_vec,
  output logic [PC_W-1:0]   old_pc
);
  localparam int IDX_W = $clog2(NUM_LINES);
  localparam int TAG_W = ADDR_W - IDX_W;

  am_op_e    op;
  logic      acc;
  logic      do_aload, do_rel, do_flash, do_seth, do_clrh, do_setk;
  logic      s_hit, e_hit, c_conf;
  logic [TAG_W-1:0]  c_old_tag;
  logic              evt, evt_multi;
  logic [ADDR_W-1:0] evt_addr;
  am_cause_e         evt_cause;
  am_cause_e         cause_q;

  assign op        = am_op_e'(cmd_op);
  assign cmd_ready = !rsp_valid || rsp_ready;
  assign acc       = cmd_valid && cmd_ready;
  assign do_aload  = acc && (op == OP_ALOAD);
  assign do_rel    = acc && (op == OP_RELEASE);
  assign do_seth   = acc && (op == OP_SET_HND);
  assign do_clrh   = acc && (op == OP_CLR_HND);
  assign do_setk   = acc && (op == OP_SET_KVEC);
  assign do_flash  = do_clrh || (acc && (op == OP_REL_ALL));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid <= 1'b0;
      rsp_word  <= '0;
    end else if (do_aload) begin
      rsp_valid <= 1'b1;
      rsp_word  <= ld_word;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

  am_mark_array #(.NUM_LINES(NUM_LINES), .IDX_W(IDX_W), .TAG_W(TAG_W)) i_marks (
    .clk       (clk),
    .rst_n     (rst_n),
    .flash_clr (do_flash),
    .set_en    (do_aload),
    .set_idx   (cmd_addr[IDX_W-1:0]),
    .set_tag   (cmd_addr[ADDR_W-1:IDX_W]),
    .rel_en    (do_rel),
    .rel_idx   (cmd_addr[IDX_W-1:0]),
    .rel_tag   (cmd_addr[ADDR_W-1:IDX_W]),
    .a_vld     (snp_valid),
    .a_idx     (snp_addr[IDX_W-1:0]),
    .a_tag     (snp_addr[ADDR_W-1:IDX_W]),
    .a_hit     (s_hit),
    .b_vld     (ev_valid),
    .b_idx     (ev_addr[IDX_W-1:0]),
    .b_tag     (ev_addr[ADDR_W-1:IDX_W]),
    .b_hit     (e_hit),
    .c_conf    (c_conf),
    .c_old_tag (c_old_tag)
  );

  am_event_arb #(.ADDR_W(ADDR_W)) i_arb (
    .s_hit     (s_hit),
    .s_addr    (snp_addr),
    .e_hit     (e_hit),
    .e_addr    (ev_addr),
    .c_hit     (c_conf),
    .c_addr    ({c_old_tag, cmd_addr[IDX_W-1:0]}),
    .evt       (evt),
    .evt_multi (evt_multi),
    .evt_addr  (evt_addr),
    .evt_cause (evt_cause)
  );

  am_alert_regs #(.ADDR_W(ADDR_W), .PC_W(PC_W)) i_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_hnd   (do_seth),
    .clr_hnd   (do_clrh),
    .set_kvec  (do_setk),
    .vec_in    (cmd_pc),
    .evt       (evt),
    .evt_multi (evt_multi),
    .evt_addr  (evt_addr),
    .evt_cause (evt_cause),
    .kmode     (kmode),
    .cur_pc    (cur_pc),
    .ack       (alert_ack),
    .alert_o   (alert_o),
    .pending   (alert_pending),
    .addr_o    (alert_addr),
    .cause_o   (cause_q),
    .target_o  (alert_target),
    .handler_o (handler_pc),
    .kvec_o    (kernel_vec),
    .old_pc_o  (old_pc)
  );

  assign alert_cause = cause_q;

  AST_RSP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |=> (rsp_valid && $stable(rsp_word))); // R1
  AST_STALL_CMD: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !rsp_ready) |-> !cmd_ready); // R1
endmodule

// File: tb/test_alert_monitor.sv
module test_alert_monitor;
  localparam int CLK_P = 10;
  localparam int NL = 8, AW = 12, PW = 16, WW = 32, IW = 3;

  logic clk = 0, rst_n = 0;
  logic cmd_valid = 0, rsp_ready = 1, snp_valid = 0, ev_valid = 0, kmode = 0, alert_ack = 0;
  logic [2:0] cmd_op = 0;
  logic [AW-1:0] cmd_addr = 0, snp_addr = 0, ev_addr = 0;
  logic [PW-1:0] cmd_pc = 0, cur_pc = 0;
  logic [WW-1:0] ld_word = 0;
  logic cmd_ready, rsp_valid, alert_o, alert_pending;
  logic [WW-1:0] rsp_word;
  logic [AW-1:0] alert_addr;
  logic [1:0] alert_cause;
  logic [PW-1:0] alert_target, handler_pc, kernel_vec, old_pc;

  int errors = 0, checks = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  alert_monitor i_alert_monitor (.*);

  // reference model state
  bit m_mk [NL];
  int m_tg [NL];
  int m_hnd, m_kv, m_addr, m_cause, m_tgt, m_opc, m_rw;
  bit m_pend, m_alert, m_rv;

  task automatic chk(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  always @(posedge clk) begin
    if (!rst_n) begin
      foreach (m_mk[i]) begin m_mk[i] = 0; m_tg[i] = 0; end
      m_hnd = 0; m_kv = 0; m_addr = 0; m_cause = 0; m_tgt = 0; m_opc = 0; m_rw = 0;
      m_pend = 0; m_alert = 0; m_rv = 0;
    end else begin
      bit acc, es, ee, ec, pe, raise;
      int si, st, ei, et, ci, ct, n, fa, fc, vec;
      acc = cmd_valid && (!m_rv || rsp_ready);
      si = snp_addr % NL; st = snp_addr / NL;
      ei = ev_addr % NL;  et = ev_addr / NL;
      ci = cmd_addr % NL; ct = cmd_addr / NL;
      es = snp_valid && m_mk[si] && m_tg[si] == st;
      ee = ev_valid && m_mk[ei] && m_tg[ei] == et;
      ec = acc && cmd_op == 2 && m_mk[ci] && m_tg[ci] != ct;
      n = es + ee + ec;
      if (es) begin fa = snp_addr; fc = 1; end
      else if (ee) begin fa = ev_addr; fc = 3; end
      else begin fa = m_tg[ci] * NL + ci; fc = 3; end
      vec = kmode ? m_kv : m_hnd;
      pe = m_pend && !alert_ack;
      raise = (n > 0) && !pe && vec != 0;
      if (raise) begin
        m_addr = fa; m_cause = (n > 1) ? 2 : fc; m_tgt = vec; m_opc = cur_pc;
      end else if (n > 0 && pe) m_cause = 2;
      m_alert = raise; m_pend = pe || raise;
      if (es) m_mk[si] = 0;
      if (ee) m_mk[ei] = 0;
      if (acc) begin
        case (cmd_op)
          0: m_hnd = cmd_pc;
          1: begin m_hnd = 0; foreach (m_mk[i]) m_mk[i] = 0; end
          2: begin m_mk[ci] = 1; m_tg[ci] = ct; end
          3: if (m_tg[ci] == ct) m_mk[ci] = 0;
          4: foreach (m_mk[i]) m_mk[i] = 0;
          5: m_kv = cmd_pc;
          default: ;
        endcase
      end
      if (acc && cmd_op == 2) begin m_rv = 1; m_rw = ld_word; end
      else if (rsp_ready) m_rv = 0;
    end
  end

  // cycle-by-cycle comparison against the model
  always @(posedge clk) begin
    #1;
    if (rst_n) begin
      chk(alert_o == m_alert && alert_pending == m_pend, "R6 strobe/pending", {alert_o, alert_pending}, {m_alert, m_pend});
      chk(alert_addr == m_addr[AW-1:0], "R4 alert_addr", alert_addr, m_addr);
      chk(alert_cause == m_cause[1:0], "R9 alert_cause", alert_cause, m_cause);
      chk(old_pc == m_opc[PW-1:0], "R6 old_pc", old_pc, m_opc);
      chk(alert_target == m_tgt[PW-1:0], "R7 alert_target", alert_target, m_tgt);
      chk(handler_pc == m_hnd[PW-1:0] && kernel_vec == m_kv[PW-1:0], "R3 vectors", {handler_pc, kernel_vec}, {m_hnd[PW-1:0], m_kv[PW-1:0]});
      chk(rsp_valid == m_rv && (!m_rv || rsp_word == m_rw[WW-1:0]), "R1 response", rsp_word, m_rw);
      chk(cmd_ready == (!m_rv || rsp_ready), "R1 cmd_ready", cmd_ready, !m_rv || rsp_ready);
    end
  end

  task automatic begin_cyc();
    @(negedge clk);
    cmd_valid = 0; snp_valid = 0; ev_valid = 0; alert_ack = 0;
  endtask
  task automatic end_cyc();
    @(posedge clk); #2;
  endtask
  task automatic cmd(input int op, input int a, input int pc);
    begin_cyc();
    cmd_valid = 1; cmd_op = 3'(op); cmd_addr = AW'(a); cmd_pc = PW'(pc); ld_word = $urandom;
    end_cyc();
  endtask
  task automatic snoop(input int a, input int pc);
    begin_cyc();
    snp_valid = 1; snp_addr = AW'(a); cur_pc = PW'(pc);
    end_cyc();
  endtask
  task automatic ack();
    begin_cyc(); alert_ack = 1; end_cyc();
  endtask

  initial begin
    #(CLK_P * 150000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    #1;
    // R12 reset state
    chk(!alert_o && !alert_pending && alert_cause == 0 && handler_pc == 0 && !rsp_valid && cmd_ready,
        "R12 reset", {alert_o, alert_pending, alert_cause, handler_pc}, 0);
    cmd(0, 0, 'h100);
    chk(handler_pc == 'h100, "R3 set handler", handler_pc, 'h100);
    // R1 alert-load with back-pressure
    begin_cyc(); rsp_ready = 0; cmd_valid = 1; cmd_op = 2; cmd_addr = 'h013; ld_word = 'hBEEF; end_cyc();
    chk(rsp_valid && rsp_word == 'hBEEF && !cmd_ready, "R1 response held", rsp_word, 'hBEEF);
    begin_cyc(); end_cyc();
    chk(rsp_valid && rsp_word == 'hBEEF, "R1 response stable", rsp_word, 'hBEEF);
    begin_cyc(); rsp_ready = 1; end_cyc();
    chk(!rsp_valid, "R1 response taken", rsp_valid, 0);
    // R4 snoop hit
    snoop('h013, 'h55);
    chk(alert_o && alert_addr == 'h013 && alert_cause == 1, "R4 snoop alert", alert_addr, 'h013);
    chk(old_pc == 'h55 && alert_target == 'h100, "R6 old pc", old_pc, 'h55);
    begin_cyc(); end_cyc();
    chk(!alert_o && alert_pending, "R6 single strobe", alert_o, 0);
    ack();
    snoop('h013, 0);
    chk(!alert_o, "R4 mark cleared by snoop", alert_o, 0);
    // R2 release one / release all
    cmd(2, 'h021, 0); cmd(2, 'h022, 0); cmd(3, 'h021, 0);
    snoop('h021, 0);
    chk(!alert_o, "R2 released line silent", alert_o, 0);
    snoop('h022, 0);
    chk(alert_o && alert_addr == 'h022, "R2 neighbour still marked", alert_addr, 'h022);
    ack();
    cmd(2, 'h031, 0); cmd(2, 'h032, 0); cmd(4, 0, 0);
    snoop('h031, 0); snoop('h032, 0);
    chk(!alert_pending, "R2 release all", alert_pending, 0);
    // R5 eviction notice and alert-load conflict
    cmd(2, 'h041, 0);
    begin_cyc(); ev_valid = 1; ev_addr = 'h041; end_cyc();
    chk(alert_o && alert_cause == 3 && alert_addr == 'h041, "R5 eviction", alert_cause, 3);
    ack();
    cmd(2, 'h045, 0); cmd(2, 'h04D, 0);
    chk(alert_o && alert_cause == 3 && alert_addr == 'h045, "R5 conflict evicts old line", alert_addr, 'h045);
    ack();
    // R7 kernel vector
    cmd(5, 0, 'h200); cmd(2, 'h011, 0);
    begin_cyc(); kmode = 1; snp_valid = 1; snp_addr = 'h011; end_cyc();
    chk(alert_o && alert_target == 'h200, "R7 kernel vector", alert_target, 'h200);
    begin_cyc(); kmode = 0; alert_ack = 1; end_cyc();
    // R8 no handler
    cmd(1, 0, 0);
    chk(handler_pc == 0, "R3 clear handler", handler_pc, 0);
    cmd(2, 'h012, 0);
    snoop('h012, 0);
    chk(!alert_o && !alert_pending, "R8 dropped without handler", alert_o, 0);
    cmd(0, 0, 'h100);
    snoop('h012, 0);
    chk(!alert_o, "R8 mark cleared on drop", alert_o, 0);
    // R9 lost alert
    cmd(2, 'h061, 0); cmd(2, 'h062, 0);
    snoop('h061, 0);
    snoop('h062, 0);
    chk(!alert_o && alert_cause == 2 && alert_addr == 'h061, "R9 lost alert", alert_cause, 2);
    ack();
    // R10 simultaneous events
    cmd(2, 'h071, 0); cmd(2, 'h072, 0);
    begin_cyc(); snp_valid = 1; snp_addr = 'h071; ev_valid = 1; ev_addr = 'h072; end_cyc();
    chk(alert_o && alert_addr == 'h071 && alert_cause == 2, "R10 ranked events", alert_addr, 'h071);
    ack();
    // R11 release and snoop in one cycle
    cmd(2, 'h073, 0);
    begin_cyc(); cmd_valid = 1; cmd_op = 3; cmd_addr = 'h073; snp_valid = 1; snp_addr = 'h073; end_cyc();
    chk(alert_o && alert_cause == 1 && alert_addr == 'h073, "R11 snoop sees old mark", alert_addr, 'h073);
    ack();
    // R11 alert-load and snoop hit together keep the mark
    cmd(2, 'h074, 0);
    begin_cyc(); cmd_valid = 1; cmd_op = 2; cmd_addr = 'h074; snp_valid = 1; snp_addr = 'h074; end_cyc();
    chk(alert_o, "R11 snoop hit with reload", alert_o, 1);
    ack();
    snoop('h074, 0);
    chk(alert_o, "R11 reloaded line marked", alert_o, 1);
    ack();
    // random phase, few tags so that collisions recur
    for (int k = 0; k < 4000; k++) begin
      begin_cyc();
      rsp_ready = ($urandom % 4) != 0;
      kmode = ($urandom % 5) == 0;
      cur_pc = $urandom;
      alert_ack = ($urandom % 3) == 0;
      cmd_valid = ($urandom % 2) == 0;
      cmd_op = ($urandom % 10 < 6) ? 3'd2 : 3'($urandom % 6);
      cmd_addr = AW'(($urandom % 3) * NL + $urandom % NL);
      cmd_pc = ($urandom % 4 == 0) ? '0 : PW'($urandom);
      ld_word = $urandom;
      snp_valid = ($urandom % 3) == 0;
      snp_addr = AW'(($urandom % 3) * NL + $urandom % NL);
      ev_valid = ($urandom % 4) == 0;
      ev_addr = AW'(($urandom % 3) * NL + $urandom % NL);
      end_cyc();
    end
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule